// File: doc/BRIEF.md
# RC4 Keystream Engine

This block produces an RC4 keystream one byte per clock. The key is first written into an internal key buffer through a byte-write port. A start pulse then latches the key length. The engine fills its 256-entry permutation with the identity, runs the key-mixing pass, and then streams keystream bytes on a valid/ready output. Key mixing and keystream generation use the same datapath: the index registers, the adder chain and the two-entry swap. After mixing finishes, that datapath is switched to generation mode. There is no separate generator.

The permutation sits in a register array. This allows three reads and a two-entry swap in a single cycle. When the output lookup lands on an entry being swapped in the same cycle, the post-swap value is forwarded, so the keystream stays exact. Combining the stream with data is left to the surrounding logic.

Top module: `rc4_stream_engine`

## Requirements
- R1: After synchronous reset, `busy` and `ks_valid` are both 0.
- R2: The edge that samples `start` begins 256 cycles of identity fill, followed by 256 cycles of key mixing. `busy` is 1 from the cycle after that edge until the first keystream byte is valid. `ks_valid` first reads 1 after the 513th rising edge following the edge that sampled `start`.
- R3: The fill writes entry x = x for x = 0..255. Mixing starts with j = 0. For i = 0..255 it sets j = j + S[i] + key[i mod L] (mod 256) and exchanges S[i] and S[j].
- R4: `key_len` gives L from 1 to 255. A value of 0 selects L = 256.
- R5: The output is the standard RC4 keystream. Generation starts with i = j = 0. Each byte does i = i+1, j = j+S[i], swaps S[i] and S[j], and emits S[S[i]+S[j]], all mod 256. For the 5-byte key 01 02 03 04 05, the stream begins b2 39 63 05.
- R6: While `ks_ready` stays 1, a new keystream byte is transferred on every clock and `ks_valid` stays 1.
- R7: While `ks_valid` is 1 and `ks_ready` is 0, `ks_byte` holds its value and the generator does not advance. No byte is lost or repeated when `ks_ready` returns.
- R8: When the output index S[i]+S[j] equals i or j, the byte emitted is the value after the swap.
- R9: A `start` pulse in any phase, including while streaming, drops `ks_valid` on the next cycle and restarts from the identity fill.
- R10: Key-buffer bytes at addresses L and above have no effect on the keystream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin fill, mixing and generation |
| key_len | input | 8 | Key length in bytes; 0 means 256 |
| key_we | input | 1 | Key buffer write enable |
| key_addr | input | 8 | Key buffer write address |
| key_wdata | input | 8 | Key buffer write data |
| busy | output | 1 | High from start until the first keystream byte is valid |
| ks_valid | output | 1 | Keystream byte valid |
| ks_ready | input | 1 | Consumer accepts the keystream byte |
| ks_byte | output | 8 | Keystream byte |

## Verification
Any fault in the permutation or in the j register reaches the ports quickly. It usually changes one of the next few keystream bytes, and from then on the stream diverges from the reference for good. The bench therefore compares long runs byte by byte against a software model. It uses three keys, one of them with the full 256-byte length, and lets the consumer stall at random points. Over hundreds of bytes, the collision cases where the output index equals i or j come up many times. A missing forward in those cases would show as a single wrong byte on the cycle it occurs. A stall that let the engine advance would show as skipped bytes right after `ks_ready` returns.

// File: rtl/rc4_pkg.sv
package rc4_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_FILL = 2'd1,
    PH_MIX  = 2'd2,
    PH_RUN  = 2'd3
  } phase_t;
endpackage

// File: rtl/rc4_key_store.sv
module rc4_key_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         we,
  input  logic [W-1:0] waddr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] raddr,
  output logic [W-1:0] rdata
);
  localparam int DEPTH = 1 << W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rc4_step_unit.sv
// Shared index/adder/select logic: mixing adds the key byte into j,
// generation leaves it out and resolves the output lookup post-swap.
module rc4_step_unit #(
  parameter int W = 8
) (
  input  logic         mix_mode,
  input  logic [W-1:0] idx_i,
  input  logic [W-1:0] j_cur,
  input  logic [W-1:0] key_b,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] s_j,
  input  logic [W-1:0] s_t,
  output logic [W-1:0] j_next,
  output logic [W-1:0] t_idx,
  output logic [W-1:0] z
);
  assign j_next = j_cur + s_i + (mix_mode ? key_b : '0);
  assign t_idx  = s_i + s_j;

  // After the exchange, entry idx_i holds s_j and entry j_next holds s_i.
  always_comb begin
    if (t_idx == idx_i)       z = s_j;
    else if (t_idx == j_next) z = s_i;
    else                      z = s_t;
  end
endmodule

// File: rtl/rc4_stream_engine.sv
module rc4_stream_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] key_len,
  input  logic         key_we,
  input  logic [W-1:0] key_addr,
  input  logic [W-1:0] key_wdata,
  output logic         busy,
  output logic         ks_valid,
  input  logic         ks_ready,
  output logic [W-1:0] ks_byte
);
  import rc4_pkg::*;

  localparam int N = 1 << W;

  phase_t       phase;
  logic [W-1:0] cnt;
  logic [W-1:0] i_q;
  logic [W-1:0] j_q;
  logic [W-1:0] kidx;
  logic [W:0]   len_eff;
  logic [W-1:0] sbox [N];

  logic [W-1:0] idx_i, j_next, t_idx, z, key_b, s_i, s_j, s_t;
  logic         mix_mode, adv, do_swap;

  assign mix_mode = (phase == PH_MIX);
  assign adv      = (phase == PH_RUN) && (!ks_valid || ks_ready);
  assign do_swap  = mix_mode || adv;
  assign idx_i    = (phase == PH_RUN) ? i_q + 1'b1 : cnt;

  assign s_i = sbox[idx_i];
  assign s_j = sbox[j_next];
  assign s_t = sbox[t_idx];

  rc4_key_store #(.W(W)) u_keys (
    .clk   (clk),
    .we    (key_we),
    .waddr (key_addr),
    .wdata (key_wdata),
    .raddr (kidx),
    .rdata (key_b)
  );

  rc4_step_unit #(.W(W)) u_step (
    .mix_mode (mix_mode),
    .idx_i    (idx_i),
    .j_cur    (j_q),
    .key_b    (key_b),
    .s_i      (s_i),
    .s_j      (s_j),
    .s_t      (s_t),
    .j_next   (j_next),
    .t_idx    (t_idx),
    .z        (z)
  );

  // Permutation storage: one write port for the fill, two for the swap.
  always_ff @(posedge clk) begin
    if (!rst && !start) begin
      if (phase == PH_FILL) begin
        sbox[cnt] <= cnt;
      end else if (do_swap) begin
        sbox[idx_i]  <= s_j;
        sbox[j_next] <= s_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      i_q      <= '0;
      j_q      <= '0;
      kidx     <= '0;
      len_eff  <= '0;
      ks_valid <= 1'b0;
      ks_byte  <= '0;
    end else if (start) begin
      phase    <= PH_FILL;
      cnt      <= '0;
      i_q      <= '0;
      j_q      <= '0;
      kidx     <= '0;
      len_eff  <= (key_len == '0) ? (W+1)'(N) : {1'b0, key_len};
      ks_valid <= 1'b0;
    end else begin
      case (phase)
        PH_FILL: begin
          cnt <= cnt + 1'b1;
          if (cnt == '1) phase <= PH_MIX;
        end
        PH_MIX: begin
          cnt  <= cnt + 1'b1;
          j_q  <= j_next;
          kidx <= ({1'b0, kidx} == len_eff - 1'b1) ? '0 : kidx + 1'b1;
          if (cnt == '1) begin
            phase <= PH_RUN;
            i_q   <= '0;
            j_q   <= '0;
          end
        end
        PH_RUN: begin
          if (adv) begin
            i_q      <= idx_i;
            j_q      <= j_next;
            ks_byte  <= z;
            ks_valid <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign busy = (phase == PH_FILL) || (phase == PH_MIX) ||
                ((phase == PH_RUN) && !ks_valid);

  // R7: a stalled byte stays put
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
    ks_valid && !ks_ready && !start |=> ks_valid && $stable(ks_byte));

  // R6: an accepted byte is followed at once by another
  p_back_to_back_r6: assert property (@(posedge clk) disable iff (rst)
    ks_valid && ks_ready && !start |=> ks_valid);

  // R2: busy and valid never overlap
  p_busy_excl_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ks_valid);

  // R2: generation is only reached from the mixing pass
  p_run_after_mix_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE || phase == PH_FILL) |=> phase != PH_RUN);

  // R4: key index stays below the effective length while mixing
  p_key_index_r4: assert property (@(posedge clk) disable iff (rst)
    phase == PH_MIX |-> {1'b0, kidx} < len_eff);

  // R9: start restarts from the fill with no valid output
  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    start |=> phase == PH_FILL && !ks_valid);
endmodule

// File: tb/rc4_stream_engine_test.sv
module rc4_stream_engine_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] key_len = '0;
  logic       key_we = 1'b0;
  logic [7:0] key_addr = '0;
  logic [7:0] key_wdata = '0;
  logic       busy, ks_valid;
  logic       ks_ready = 1'b0;
  logic [7:0] ks_byte;

  always #10 clk = ~clk;

  rc4_stream_engine uut (
    .clk(clk), .rst(rst), .start(start), .key_len(key_len),
    .key_we(key_we), .key_addr(key_addr), .key_wdata(key_wdata),
    .busy(busy), .ks_valid(ks_valid), .ks_ready(ks_ready), .ks_byte(ks_byte)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int xfers = 0;
  bit done = 0;
  bit rand_ready = 0;
  logic [15:0] lfsr = 16'hace1;
  logic [7:0] exp_q [$];
  logic [7:0] kmem [256];
  int ms [256];
  int mi, mj;
  bit hold_chk = 0;
  logic [7:0] held = '0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (cyc == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
  end

  // Ready driver: only accept while expectations are pending.
  always @(posedge clk) begin
    #1 ks_ready = (exp_q.size() > 0) && (!rand_ready || lfsr[3]);
  end

  // Monitor: scoreboard compare and stall stability (R5, R7, R8).
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_chk) chk(ks_valid && ks_byte == held, "R7 held byte", ks_byte, held);
      hold_chk = ks_valid && !ks_ready && !start;
      held = ks_byte;
      if (ks_valid && ks_ready && !start) begin
        xfers++;
        if (exp_q.size() > 0) begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(ks_byte == e, "R5/R8 keystream", ks_byte, e);
        end
      end
    end
  end

  task automatic model_schedule(input int len);
    int j, tmp;
    for (int i = 0; i < 256; i++) ms[i] = i;
    j = 0;
    for (int i = 0; i < 256; i++) begin
      j = (j + ms[i] + int'(kmem[i % len])) & 255;
      tmp = ms[i]; ms[i] = ms[j]; ms[j] = tmp;
    end
    mi = 0;
    mj = 0;
  endtask

  task automatic model_next(output logic [7:0] b);
    int tmp;
    mi = (mi + 1) & 255;
    mj = (mj + ms[mi]) & 255;
    tmp = ms[mi]; ms[mi] = ms[mj]; ms[mj] = tmp;
    b = 8'(ms[(ms[mi] + ms[mj]) & 255]);
  endtask

  task automatic push_expected(input int n);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      model_next(b);
      exp_q.push_back(b);
    end
  endtask

  task automatic write_key(input int a, input logic [7:0] d);
    @(posedge clk); #1;
    key_we = 1'b1; key_addr = 8'(a); key_wdata = d;
    kmem[a] = d;
    @(posedge clk); #1;
    key_we = 1'b0;
  endtask

  task automatic launch(input logic [7:0] len);
    int n;
    @(posedge clk); #1;
    start = 1'b1; key_len = len;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(ks_valid == 1'b0, "R9 valid cleared by start", ks_valid, 0);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!ks_valid && n < 2000);
    chk(n == 513, "R2 first valid latency", n, 513);
    chk(busy == 1'b0, "R2 busy low once valid", busy, 0);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [7:0] b;
    int x0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(ks_valid == 1'b0, "R1 valid after reset", ks_valid, 0);

    // Key 01..05, bytes above the length filled with junk (R10).
    for (int a = 0; a < 256; a++) write_key(a, 8'(a * 37 + 11));
    for (int a = 0; a < 5; a++) write_key(a, 8'(a + 1));
    launch(8'd5);
    model_schedule(5);
    // R5 known prefix of the 5-byte key stream
    model_next(b); chk(b == 8'hb2, "R5 known byte 0", b, 8'hb2); exp_q.push_back(b);
    model_next(b); chk(b == 8'h39, "R5 known byte 1", b, 8'h39); exp_q.push_back(b);
    model_next(b); chk(b == 8'h63, "R5 known byte 2", b, 8'h63); exp_q.push_back(b);
    model_next(b); chk(b == 8'h05, "R5 known byte 3", b, 8'h05); exp_q.push_back(b);
    push_expected(60);
    // R6: with ready high every cycle, one transfer per clock
    repeat (4) @(negedge clk);
    x0 = xfers;
    repeat (32) @(negedge clk);
    chk(xfers - x0 == 32, "R6 one byte per clock", xfers - x0, 32);
    drain();
    // R7, R8: random stalls over a long run (R10 via junk key tail)
    rand_ready = 1;
    push_expected(400);
    drain();
    rand_ready = 0;

    // R4: length code 0 means a 256-byte key; restart mid-stream (R9)
    for (int a = 0; a < 256; a++) write_key(a, 8'(a * 7 + 3));
    launch(8'd0);
    model_schedule(256);
    rand_ready = 1;
    push_expected(96);
    drain();

    // R3: single-byte key
    write_key(0, 8'h2a);
    launch(8'd1);
    model_schedule(1);
    push_expected(48);
    drain();
    rand_ready = 0;

    finish_run();
  end
endmodule